// File: doc/BRIEF.md
# Link Error Lock Monitor

This block sits beside the decoder of a serial link receiver and decides when the receiver's lock indication has to be withdrawn. On every pixel-clock cycle it looks at three error strobes: one for each of two clock channels and one for the data/control channel. If any of the three strobes is high, that cycle counts as one error event.

A configuration bit picks one of two policies. With counting off, the first error event while locked drops the lock. With counting on, error events are added up from the moment lock is acquired. The lock drops when that running total reaches a 4-bit threshold. The surrounding register bank sets this threshold and normally resets it to 3.

The lock output is registered. It goes high one cycle after a lock-acquired pulse and goes low one cycle after the deciding error event. It then stays low until the next lock-acquired pulse. The current error tally is exposed alongside it.

Top module: `link_err_lock_mon`

## Requirements
- R1: While reset is asserted, and after it is released with no lock-acquired pulse, `lock_o` is 0 and `err_cnt_o` is 0.
- R2: A cycle with `lock_acq_i` high makes `lock_o` 1 and `err_cnt_o` 0 in the following cycle, whatever the error strobes and the prior state were.
- R3: A cycle counts as one error event when at least one of the three strobes is high. Two or three strobes in the same cycle count as a single event.
- R4: With `cnt_en_i` = 1, while locked, each error event that does not reach the threshold raises `err_cnt_o` by exactly one in the next cycle, and `lock_o` stays 1.
- R5: With `cnt_en_i` = 1, `lock_o` falls in the cycle after the error event that brings the running total up to `thresh_i`. A `thresh_i` of 0 behaves exactly as a `thresh_i` of 1.
- R6: With `cnt_en_i` = 0, any error event on any source while locked makes `lock_o` 0 in the next cycle.
- R7: While `lock_o` is 0, `err_cnt_o` is 0 and error strobes are ignored. `lock_o` stays 0 until a lock-acquired pulse arrives.
- R8: A locked cycle with no error event and no lock-acquired pulse leaves `lock_o` and `err_cnt_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_clk0_i | input | 1 | Error strobe, first clock channel |
| err_clk1_i | input | 1 | Error strobe, second clock channel |
| err_dc_i | input | 1 | Error strobe, data/control channel |
| lock_acq_i | input | 1 | Lock-acquired pulse from the lock detector |
| cnt_en_i | input | 1 | 1: accumulate errors against threshold; 0: drop on first error |
| thresh_i | input | CNT_W | Error count threshold (0 treated as 1) |
| lock_o | output | 1 | Registered lock status |
| err_cnt_o | output | CNT_W | Error events counted since the last lock acquisition |

## Verification
The bench sweeps every threshold value under both policies. For each one it applies a rotating mix of single-source, multi-source and idle cycles and compares the outputs against an arithmetic model on every cycle.

- An off-by-one in the threshold compare shows up as lock dropping one event too early or too late.
- Mishandling threshold 0 shows up as a lock that never drops or drops on the wrong event.
- Adding up the sources instead of merging them shows up as a count jump of two or three.
- A lock-acquired pulse that coincides with errors must still leave a clean count of zero.
- Errors that arrive while unlocked must neither disturb the zero count nor bring the lock back.

// File: rtl/lelm_pkg.sv
package lelm_pkg;
  localparam int unsigned LELM_CNT_W   = 4;
  localparam int unsigned LELM_NUM_SRC = 3;
endpackage

// File: rtl/lelm_err_merge.sv
module lelm_err_merge #(
  parameter int unsigned NUM_SRC = lelm_pkg::LELM_NUM_SRC
) (
  input  logic [NUM_SRC-1:0] src_i,
  output logic               event_o
);
  // Per-source OR chain: any number of simultaneous strobes is one event.
  logic [NUM_SRC:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_or
    assign chain[g+1] = chain[g] | src_i[g];
  end
  assign event_o = chain[NUM_SRC];
endmodule

// File: rtl/lelm_err_counter.sv
module lelm_err_counter #(
  parameter int unsigned CNT_W = lelm_pkg::LELM_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_plus_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Saturating increment, offered to the lock decision ahead of the register.
  always_comb begin
    if (cnt_q == CNT_MAX) cnt_plus_o = CNT_MAX;
    else                  cnt_plus_o = cnt_q + 1'b1;
  end

  always_comb begin
    cnt_en = clr_i | inc_i;
    cnt_d  = clr_i ? '0 : cnt_plus_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lelm_lock_ctrl.sv
module lelm_lock_ctrl #(
  parameter int unsigned CNT_W = lelm_pkg::LELM_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_i,
  input  logic             event_i,
  input  logic             cnt_en_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic [CNT_W-1:0] cnt_plus_i,
  output logic             lock_o,
  output logic             drop_o
);
  logic [CNT_W-1:0] eff_thresh;
  logic             lock_q, lock_d, lock_we;
  logic             limit_hit;

  always_comb begin
    eff_thresh = (thresh_i == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : thresh_i;
    limit_hit  = (cnt_plus_i >= eff_thresh);
    drop_o     = lock_q & ~acq_i & event_i & (~cnt_en_i | limit_hit);
    lock_we    = acq_i | drop_o;
    lock_d     = acq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (lock_we) lock_q <= lock_d;
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/link_err_lock_mon.sv
module link_err_lock_mon #(
  parameter int unsigned CNT_W = lelm_pkg::LELM_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_clk0_i,
  input  logic             err_clk1_i,
  input  logic             err_dc_i,
  input  logic             lock_acq_i,
  input  logic             cnt_en_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             lock_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  localparam int unsigned NSRC = lelm_pkg::LELM_NUM_SRC;

  logic             err_event;
  logic             drop;
  logic             cnt_clr;
  logic             cnt_inc;
  logic [CNT_W-1:0] cnt_plus;

  lelm_err_merge #(.NUM_SRC(NSRC)) u_merge (
    .src_i   ({err_dc_i, err_clk1_i, err_clk0_i}),
    .event_o (err_event)
  );

  lelm_lock_ctrl #(.CNT_W(CNT_W)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .acq_i      (lock_acq_i),
    .event_i    (err_event),
    .cnt_en_i   (cnt_en_i),
    .thresh_i   (thresh_i),
    .cnt_plus_i (cnt_plus),
    .lock_o     (lock_o),
    .drop_o     (drop)
  );

  // Counter is zero outside lock, cleared on acquisition and on loss.
  always_comb begin
    cnt_clr = lock_acq_i | drop | ~lock_o;
    cnt_inc = lock_o & err_event;
  end

  lelm_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (cnt_clr),
    .inc_i      (cnt_inc),
    .cnt_o      (err_cnt_o),
    .cnt_plus_o (cnt_plus)
  );
endmodule

// File: rtl/lelm_checker.sv
module lelm_checker #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_clk0_i,
  input logic             err_clk1_i,
  input logic             err_dc_i,
  input logic             lock_acq_i,
  input logic             cnt_en_i,
  input logic [CNT_W-1:0] thresh_i,
  input logic             lock_o,
  input logic [CNT_W-1:0] err_cnt_o
);
  logic           any_err;
  logic [CNT_W:0] next_tally;
  logic [CNT_W:0] thr_eff;

  assign any_err    = err_clk0_i | err_clk1_i | err_dc_i;
  assign next_tally = {1'b0, err_cnt_o} + 1'b1;
  assign thr_eff    = (thresh_i == '0) ? 1 : {1'b0, thresh_i};

  assert_acquire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_acq_i |=> (lock_o && err_cnt_o == '0));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !lock_acq_i && any_err && cnt_en_i && next_tally < thr_eff)
      |=> (lock_o && err_cnt_o == $past(err_cnt_o) + 1'b1));

  assert_threshold_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !lock_acq_i && any_err && cnt_en_i && next_tally >= thr_eff)
      |=> !lock_o);

  assert_first_error_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !lock_acq_i && any_err && !cnt_en_i) |=> !lock_o);

  assert_unlocked_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_o |-> err_cnt_o == '0);

  assert_stay_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_o && !lock_acq_i) |=> !lock_o);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !lock_acq_i && !any_err) |=> (lock_o && $stable(err_cnt_o)));
endmodule

bind link_err_lock_mon lelm_checker #(.CNT_W(CNT_W)) u_lelm_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .err_clk0_i (err_clk0_i),
  .err_clk1_i (err_clk1_i),
  .err_dc_i   (err_dc_i),
  .lock_acq_i (lock_acq_i),
  .cnt_en_i   (cnt_en_i),
  .thresh_i   (thresh_i),
  .lock_o     (lock_o),
  .err_cnt_o  (err_cnt_o)
);

// File: tb/link_err_lock_mon_test.sv
`timescale 1ns/1ps
module link_err_lock_mon_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       e0, e1, e2, acq, en;
  logic [3:0] thr;
  logic       lock_o;
  logic [3:0] err_cnt_o;

  int checks = 0;
  int fails  = 0;
  bit m_lock = 1'b0;
  int m_cnt  = 0;

  always #5 clk = ~clk;

  link_err_lock_mon uut (
    .clk(clk), .rst_n(rst_n), .err_clk0_i(e0), .err_clk1_i(e1), .err_dc_i(e2),
    .lock_acq_i(acq), .cnt_en_i(en), .thresh_i(thr),
    .lock_o(lock_o), .err_cnt_o(err_cnt_o)
  );

  task automatic check(input string tag);
    checks++;
    if (lock_o !== m_lock || err_cnt_o !== 4'(m_cnt)) begin
      fails++;
      $display("FAIL %s lock=%0b exp=%0b cnt=%0d exp=%0d", tag, lock_o, m_lock, err_cnt_o, m_cnt);
    end
  endtask

  // One pixel cycle: drive at negedge, model the edge, sample 1 ns after it.
  task automatic step(input logic [2:0] errs, input logic a, input string tag);
    int eff, nc;
    @(negedge clk);
    {e2, e1, e0} = errs;
    acq = a;
    @(posedge clk);
    #1;
    eff = (thr == 0) ? 1 : int'(thr);
    if (a) begin
      m_lock = 1'b1; m_cnt = 0;
    end else if (!m_lock) begin
      m_cnt = 0;
    end else if (errs != 3'b000) begin
      nc = (m_cnt == 15) ? 15 : m_cnt + 1;
      if (!en || nc >= eff) begin m_lock = 1'b0; m_cnt = 0; end
      else m_cnt = nc;
    end
    check(tag);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired lock=%0b exp=%0b", lock_o, m_lock);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; {e0, e1, e2, acq} = '0; en = 1'b1; thr = 4'd3;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    step(3'b111, 1'b0, "R1 after release");
    step(3'b000, 1'b0, "R1 idle");

    // R7: errors before any lock are ignored
    for (int i = 1; i < 8; i++) step(3'(i), 1'b0, "R7 unlocked errors");

    // R2: acquisition with all errors present
    step(3'b111, 1'b1, "R2 acquire under errors");
    // R3: multi-source cycle counts once
    thr = 4'd15;
    step(3'b111, 1'b0, "R3 three sources");
    step(3'b011, 1'b0, "R3 two sources");
    step(3'b100, 1'b0, "R3 one source");
    // R8: idle cycles hold
    repeat (4) step(3'b000, 1'b0, "R8 idle hold");
    // R2: re-acquire while locked clears count
    step(3'b001, 1'b1, "R2 reacquire clears");

    // R6: each source alone drops lock with counting off
    en = 1'b0;
    for (int s = 0; s < 3; s++) begin
      step(3'b000, 1'b1, "R2 acquire");
      step(3'(1 << s), 1'b0, "R6 single source drop");
      step(3'b010, 1'b0, "R7 stays unlocked");
    end

    // R4/R5/R6 sweep: every threshold, both policies, mixed patterns
    for (int e = 0; e < 2; e++) begin
      for (int t = 0; t < 16; t++) begin
        en = e[0]; thr = 4'(t);
        step(3'b000, 1'b1, "R2 sweep acquire");
        for (int k = 0; k < 20; k++) begin
          logic [2:0] p;
          p = (k % 3 == 2) ? 3'b000 : 3'((k * 5 + t) % 7 + 1);
          step(p, 1'b0, e ? "R4 R5 counted sweep" : "R6 direct sweep");
        end
      end
    end

    // R5: threshold 0 equals 1
    en = 1'b1; thr = 4'd0;
    step(3'b000, 1'b1, "R2 acquire");
    step(3'b000, 1'b0, "R8 idle");
    step(3'b010, 1'b0, "R5 threshold zero drop");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule